// File: doc/BRIEF.md
# USB Full-Speed Line Receiver

This block sits behind a synchroniser on the two full-speed USB data lines. It takes one sample of the line pair per clock, at four samples per 12 Mbit/s bit. Each sample is sorted into one of four line states. A state that shows up for a single sample is treated as noise. The block waits for a state to be seen on two samples in a row before it accepts it, then times how long each accepted state lasts.

Bits are recovered from those run lengths. A change between the two differential states gives a zero. Each further bit interval spent in the same state gives a one, released as that interval elapses. A zero that follows six ones is a stuffed bit and is removed. A seventh one is flagged as a stuffing violation.

When a single-ended-zero run ends, the block looks at its length. A short run closes the packet. A long run is reported as a bus reset. Downstream packet logic consumes the bit strobe and the three event pulses, all synchronous to the sample clock.

Top module: `usb_fs_line_rx`

## Requirements
- R1: Each sample of {dp,dm} maps to a line state: 1,0 is J; 0,1 is K; 0,0 is SE0; 1,1 is SE1. A J run, an SE1 run and the return to J produce no bit, eop, bus_rst or stuff_err when the block is idle.
- R2: An accepted state lasting L samples spans floor((L+2)/4) bit intervals. Inside a packet, every interval after the first gives bit_valid=1 with bit_data=1. An accepted change between J and K gives bit_valid=1 with bit_data=0.
- R3: A J/K change that directly follows exactly six consecutive output ones is a stuffed bit and gives no bit_valid.
- R4: When a seventh consecutive one would be output, stuff_err pulses for one cycle and that one is not output. Further ones in the same run are dropped without another pulse. The next J/K change still outputs its zero.
- R5: A line state seen on only one sample is ignored. It produces no output, and the surrounding run is timed as if the glitch were absent.
- R6: When an SE0 run of 2 to 13 samples (1 to 3 bit intervals) ends, eop pulses for one cycle. The block returns to idle with its ones count cleared.
- R7: When an SE0 run of 14 or more samples (4 or more bit intervals) ends, bus_rst pulses for one cycle instead of eop, and the block returns to idle.
- R8: While idle, a J run produces no bits. The first J/K change after idle outputs a zero and starts a packet.
- R9: A synchronous reset drives all outputs low and returns the block to idle in J, with its sample counter and ones count cleared.
- R10: At most one of bit_valid, eop, bus_rst and stuff_err is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, four samples per bit |
| rst | input | 1 | Synchronous reset, active high |
| dp | input | 1 | Synchronised positive data line |
| dm | input | 1 | Synchronised negative data line |
| bit_valid | output | 1 | A decoded bit is present on bit_data this cycle |
| bit_data | output | 1 | Decoded, unstuffed bit value |
| eop | output | 1 | One-cycle end-of-packet pulse |
| bus_rst | output | 1 | One-cycle bus-reset pulse after a long SE0 |
| stuff_err | output | 1 | One-cycle pulse on a run of more than six ones |

## Verification
Some properties hold on every cycle, and the assertions watch these. The four outputs never pulse together. A zero never leaves the block while the ones count sits at six. stuff_err appears only when the count is exactly six. Ones appear only inside a packet. Every accepted run lasts at least two samples. Every eop or bus_rst follows an SE0 run. Other behaviour only shows up in the bench's scenarios: the rounding of run lengths into intervals, the exact boundary between eop and bus_rst, the removal of glitches without shifting bit timing, and the clearing of the ones count by reset. The bench sweeps run lengths and SE0 lengths sample by sample and compares the bit stream it collects against values it works out for itself.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

   // Encoding is {dm, dp}: J = 01, K = 10.
   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_SE1 = 2'b11
   } line_t;

   function automatic logic is_diff(input line_t s);
      return (s == LS_J) || (s == LS_K);
   endfunction

endpackage

// File: rtl/usb_rx_line_state.sv
module usb_rx_line_state
   import usb_rx_pkg::*;
#(
   parameter bit IN_REG = 1'b1
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  dp,
   input  logic  dm,
   output line_t ls
);

   line_t ls_raw;

   always_comb begin
      unique case ({dm, dp})
         2'b01:   ls_raw = LS_J;
         2'b10:   ls_raw = LS_K;
         2'b00:   ls_raw = LS_SE0;
         default: ls_raw = LS_SE1;
      endcase
   end

   generate
      if (IN_REG) begin : g_reg
         line_t ls_q;
         always_ff @(posedge clk) begin
            if (rst) ls_q <= LS_J;
            else     ls_q <= ls_raw;
         end
         assign ls = ls_q;
      end else begin : g_comb
         assign ls = ls_raw;
      end
   endgenerate

endmodule

// File: rtl/usb_rx_run_tracker.sv
module usb_rx_run_tracker
   import usb_rx_pkg::*;
#(
   parameter int OVS   = 4,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  line_t            ls,
   output logic             commit,
   output line_t            cur,
   output line_t            nxt,
   output logic [CNT_W-1:0] old_bits,
   output logic             mid_bit
);

   localparam int               SH    = $clog2(OVS);
   localparam int               FIRST = OVS + OVS / 2 + 1;
   localparam logic [CNT_W-1:0] CMAX  = '1;

   generate
      if ((1 << SH) != OVS || OVS < 4) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (CNT_W < SH + 2) begin : g_bad_cnt
         $error("CNT_W too small for OVS");
      end
   endgenerate

   line_t            ls_d, cur_q;
   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic [CNT_W:0]   len_rnd;
   logic [CNT_W-1:0] off;

   assign commit = (ls == ls_d) && (ls != cur_q);
   assign cur    = cur_q;
   assign nxt    = ls;

   always_comb begin
      if (commit)             cnt_nx = CNT_W'(2);
      else if (cnt_q == CMAX) cnt_nx = CMAX;
      else                    cnt_nx = cnt_q + 1'b1;
   end

   // cnt_q counts the finished run plus the first sample of the new state.
   assign len_rnd  = {1'b0, cnt_q} + (CNT_W + 1)'(OVS / 2 - 1);
   assign old_bits = CNT_W'(len_rnd >> SH);

   assign off     = cnt_nx - CNT_W'(FIRST);
   assign mid_bit = !commit && (cnt_q != CMAX) &&
                    (cnt_nx >= CNT_W'(FIRST)) && (off[SH-1:0] == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         ls_d  <= LS_J;
         cur_q <= LS_J;
         cnt_q <= CNT_W'(2);
      end else begin
         ls_d  <= ls;
         cnt_q <= cnt_nx;
         if (commit) cur_q <= ls;
      end
   end

   p_min_run_r5 : assert property (@(posedge clk) disable iff (rst)
      commit |-> (cnt_q >= CNT_W'(3)));

endmodule

// File: rtl/usb_rx_unstuff.sv
module usb_rx_unstuff
   import usb_rx_pkg::*;
#(
   parameter int CNT_W          = 8,
   parameter int STUFF_LIMIT    = 6,
   parameter int RESET_MIN_BITS = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             commit,
   input  line_t            cur,
   input  line_t            nxt,
   input  logic [CNT_W-1:0] old_bits,
   input  logic             mid_bit,
   output logic             bit_valid,
   output logic             bit_data,
   output logic             eop,
   output logic             bus_rst,
   output logic             stuff_err
);

   localparam int                ONES_W = $clog2(STUFF_LIMIT + 2);
   localparam logic [ONES_W-1:0] LIM    = ONES_W'(STUFF_LIMIT);
   localparam logic [ONES_W-1:0] OVER   = ONES_W'(STUFF_LIMIT + 1);

   generate
      if (STUFF_LIMIT < 1) begin : g_bad_lim
         $error("STUFF_LIMIT must be positive");
      end
      if (RESET_MIN_BITS < 2 || RESET_MIN_BITS >= (1 << CNT_W) / 8) begin : g_bad_rst
         $error("RESET_MIN_BITS out of range for CNT_W");
      end
   endgenerate

   logic              in_pkt_q, in_pkt_d;
   logic [ONES_W-1:0] ones_q, ones_d;
   logic              bv_d, bd_d, eop_d, rst_d, err_d;
   logic              bv_q, bd_q, eop_q, rstp_q, err_q;

   always_comb begin
      in_pkt_d = in_pkt_q;
      ones_d   = ones_q;
      bv_d     = 1'b0;
      bd_d     = 1'b0;
      eop_d    = 1'b0;
      rst_d    = 1'b0;
      err_d    = 1'b0;
      if (commit) begin
         if (cur == LS_SE0) begin
            if (old_bits < CNT_W'(RESET_MIN_BITS)) eop_d = 1'b1;
            else                                   rst_d = 1'b1;
            in_pkt_d = 1'b0;
            ones_d   = '0;
         end else if (is_diff(cur) && is_diff(nxt)) begin
            in_pkt_d = 1'b1;
            ones_d   = '0;
            if (ones_q != LIM) bv_d = 1'b1;
         end else begin
            ones_d = '0;
         end
      end else if (mid_bit && in_pkt_q && is_diff(cur)) begin
         if (ones_q < LIM) begin
            bv_d   = 1'b1;
            bd_d   = 1'b1;
            ones_d = ones_q + 1'b1;
         end else if (ones_q == LIM) begin
            err_d  = 1'b1;
            ones_d = OVER;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         in_pkt_q <= 1'b0;
         ones_q   <= '0;
         bv_q     <= 1'b0;
         bd_q     <= 1'b0;
         eop_q    <= 1'b0;
         rstp_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         in_pkt_q <= in_pkt_d;
         ones_q   <= ones_d;
         bv_q     <= bv_d;
         bd_q     <= bd_d;
         eop_q    <= eop_d;
         rstp_q   <= rst_d;
         err_q    <= err_d;
      end
   end

   assign bit_valid = bv_q;
   assign bit_data  = bd_q;
   assign eop       = eop_q;
   assign bus_rst   = rstp_q;
   assign stuff_err = err_q;

   p_stuffed_zero_dropped_r3 : assert property (@(posedge clk) disable iff (rst)
      (bv_q && !bd_q) |-> ($past(ones_q) != LIM));

   p_err_at_limit_r4 : assert property (@(posedge clk) disable iff (rst)
      err_q |-> ($past(ones_q) == LIM));

   p_idle_no_ones_r8 : assert property (@(posedge clk) disable iff (rst)
      (bv_q && bd_q) |-> $past(in_pkt_q));

endmodule

// File: rtl/usb_fs_line_rx.sv
module usb_fs_line_rx
   import usb_rx_pkg::*;
#(
   parameter int OVS            = 4,
   parameter int CNT_W          = 8,
   parameter int STUFF_LIMIT    = 6,
   parameter int RESET_MIN_BITS = 4,
   parameter bit IN_REG         = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic dp,
   input  logic dm,
   output logic bit_valid,
   output logic bit_data,
   output logic eop,
   output logic bus_rst,
   output logic stuff_err
);

   line_t            ls, cur, nxt;
   logic             commit, mid_bit;
   logic [CNT_W-1:0] old_bits;

   usb_rx_line_state #(.IN_REG(IN_REG)) u_line (
      .clk (clk),
      .rst (rst),
      .dp  (dp),
      .dm  (dm),
      .ls  (ls)
   );

   usb_rx_run_tracker #(.OVS(OVS), .CNT_W(CNT_W)) u_track (
      .clk      (clk),
      .rst      (rst),
      .ls       (ls),
      .commit   (commit),
      .cur      (cur),
      .nxt      (nxt),
      .old_bits (old_bits),
      .mid_bit  (mid_bit)
   );

   usb_rx_unstuff #(
      .CNT_W          (CNT_W),
      .STUFF_LIMIT    (STUFF_LIMIT),
      .RESET_MIN_BITS (RESET_MIN_BITS)
   ) u_unstuff (
      .clk       (clk),
      .rst       (rst),
      .commit    (commit),
      .cur       (cur),
      .nxt       (nxt),
      .old_bits  (old_bits),
      .mid_bit   (mid_bit),
      .bit_valid (bit_valid),
      .bit_data  (bit_data),
      .eop       (eop),
      .bus_rst   (bus_rst),
      .stuff_err (stuff_err)
   );

   p_single_event_r10 : assert property (@(posedge clk) disable iff (rst)
      $onehot0({bit_valid, eop, bus_rst, stuff_err}));

   p_end_after_se0_r6 : assert property (@(posedge clk) disable iff (rst)
      (eop || bus_rst) |-> ($past(cur) == LS_SE0));

endmodule

// File: tb/test_usb_fs_line_rx.sv
module test_usb_fs_line_rx;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic dp  = 1'b1;
   logic dm  = 1'b0;
   logic bit_valid, bit_data, eop, bus_rst, stuff_err;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic cap [0:255];
   int   ncap = 0, neop = 0, nrst = 0, nerr = 0;
   logic pkt [0:63];
   logic exp_b [0:63];
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   usb_fs_line_rx i_usb_fs_line_rx (
      .clk (clk), .rst (rst), .dp (dp), .dm (dm),
      .bit_valid (bit_valid), .bit_data (bit_data),
      .eop (eop), .bus_rst (bus_rst), .stuff_err (stuff_err)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (bit_valid) begin
            if (ncap < 256) cap[ncap] = bit_data;
            ncap++;
         end
         if (eop)       neop++;
         if (bus_rst)   nrst++;
         if (stuff_err) nerr++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input int act, input int exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clr();
      ncap = 0; neop = 0; nrst = 0; nerr = 0;
   endtask

   task automatic put(input logic p, input logic m, input int n);
      for (int i = 0; i < n; i++) begin
         dp = p; dm = m;
         @(negedge clk);
      end
   endtask

   // j=1 drives J, j=0 drives K
   task automatic lvl(input logic j, input int n);
      put(j, ~j, n);
   endtask

   function automatic int cmp_bits(input int n);
      int miss = 0;
      for (int i = 0; i < n && i < 256; i++)
         if (cap[i] !== exp_b[i]) miss++;
      return miss;
   endfunction

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   // NRZI encode with stuffing; optional one-sample glitch inside bit gi
   task automatic send_pkt(input int n, input int gi, input int gkind);
      logic l = 1'b1;
      int ones = 0;
      lvl(1'b1, 8);
      for (int i = 0; i < n; i++) begin
         if (pkt[i] == 1'b0) begin l = ~l; ones = 0; end
         else ones++;
         if (i == gi && pkt[i] == 1'b1) begin
            lvl(l, 1);
            if (gkind == 0) lvl(~l, 1); else put(1'b0, 1'b0, 1);
            lvl(l, 2);
         end else begin
            lvl(l, 4);
         end
         if (ones == 6) begin l = ~l; ones = 0; lvl(l, 4); end
      end
      put(1'b0, 1'b0, 8);
      lvl(1'b1, 12);
   endtask

   task automatic run_sweep(input int len, input string tag);
      int n, ne, k;
      n = (len + 2) / 4 - 1;
      k = 0;
      exp_b[k++] = 1'b0;
      for (int i = 0; i < n && i < 6; i++) exp_b[k++] = 1'b1;
      if (n != 6) exp_b[k++] = 1'b0;
      exp_b[k++] = 1'b1;
      ne = (n > 6) ? 1 : 0;
      clr();
      lvl(1'b1, 8);
      lvl(1'b0, len);
      lvl(1'b1, 8);
      put(1'b0, 1'b0, 8);
      lvl(1'b1, 12);
      check(ncap, k, {tag, " bit count"});
      check(cmp_bits(k), 0, {tag, " bit values"});
      check(nerr, ne, {tag, " stuff_err count (R4)"});
      check(neop, 1, {tag, " eop count (R6)"});
   endtask

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check(int'({bit_valid, eop, bus_rst, stuff_err}), 0, "R9 outputs low in reset");
      rst = 1'b0;
      lvl(1'b1, 4);
      check(int'({bit_valid, eop, bus_rst, stuff_err}), 0, "R9 outputs low after reset");

      // R1/R8: idle J and SE1 produce nothing
      clr();
      lvl(1'b1, 40);
      put(1'b1, 1'b1, 12);
      lvl(1'b1, 12);
      check(ncap + neop + nrst + nerr, 0, "R1 R8 idle J and SE1 silent");

      // R2 R3 R4: run-length sweep over the K state
      for (int len = 2; len <= 34; len++) run_sweep(len, $sformatf("R2 R3 len=%0d", len));

      // R6 R7: SE0 length sweep, R5 for a one-sample SE0
      for (int len = 1; len <= 20; len++) begin
         clr();
         lvl(1'b1, 8);
         put(1'b0, 1'b0, len);
         lvl(1'b1, 12);
         check(neop, (len >= 2 && len <= 13) ? 1 : 0, $sformatf("R6 eop se0=%0d", len));
         check(nrst, (len >= 14) ? 1 : 0, $sformatf("R7 bus_rst se0=%0d", len));
         check(ncap, 0, $sformatf("R8 no bits se0=%0d", len));
      end

      // R2 R3: pseudo-random packets, some with glitches (R5)
      for (int p = 0; p < 16; p++) begin
         int gi;
         pkt[0] = 1'b0;
         for (int i = 1; i < 32; i++) begin step_lfsr(); pkt[i] = lfsr[0]; end
         if (p == 3) for (int i = 1; i < 24; i++) pkt[i] = 1'b1;
         for (int i = 0; i < 32; i++) exp_b[i] = pkt[i];
         gi = -1;
         if (p >= 4 && p < 10)
            for (int i = 31; i > 1; i--) if (pkt[i] == 1'b1) gi = i;
         clr();
         send_pkt(32, gi, p & 1);
         check(ncap, 32, $sformatf("R2 pkt%0d bit count", p));
         check(cmp_bits(32), 0, $sformatf("R3 R5 pkt%0d bit values", p));
         check(neop + 8 * nrst + 16 * nerr, 1, $sformatf("R6 pkt%0d single eop", p));
      end

      // R9: reset mid-packet clears the ones count
      clr();
      lvl(1'b1, 8);
      lvl(1'b0, 14);
      rst = 1'b1;
      lvl(1'b1, 3);
      rst = 1'b0;
      check(int'({bit_valid, eop, bus_rst, stuff_err}), 0, "R9 outputs low after mid-packet reset");
      run_sweep(18, "R9 after reset");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule